// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block is the next-address engine of a microcoded control unit. It owns a 2048-entry control store of 41-bit microwords and a microinstruction register holding the word now in execution. On every clock it chooses the address of the next microword, fetches that word into the register, and presents the decoded fields of the word to the datapath it steers. The datapath itself is outside this block. The only inputs from the datapath are four status flags (negative, zero, overflow, carry) and the 32-bit instruction word being interpreted.

There are three sources for the next address. The first is the current address plus one. The second is the jump target carried in the microword, taken always or only when a selected flag or instruction bit 13 is set. The third is a dispatch address built from the opcode bits of the instruction word, so that one microstep jumps straight to the handler for any opcode. A write port fills the store, before reset is released or while the sequencer runs. The sequencer flags any microword that asks for a memory read and a memory write at once.

Top module: `useq_top`

## Requirements
- R1: The field outputs are slices of the microword in the register, counted from bit 40 down: aSel[40:35], aFromIr[34], bSel[33:28], bFromIr[27], cSel[26:21], cFromIr[20], memRd[19], memWr[18], aluOp[17:14], condCode[13:11], jumpAddr[10:0].
- R2: While rst is high, on every rising edge csAddr is set to 0 and the register is loaded with the word at store address 0. After rst falls, that word executes first.
- R3: condCode 0 makes the next address csAddr+1.
- R4: condCode 1, 2, 3, 4 and 5 jump to jumpAddr when flagN, flagZ, flagV, flagC or ir[13] respectively is 1. When the tested bit is 0, the next address is csAddr+1.
- R5: condCode 6 always jumps to jumpAddr.
- R6: condCode 7 makes the next address {1, ir[31:30], ir[24:19], 2'b00}.
- R7: Incrementing from address 2047 gives address 0.
- R8: rdWrErr is 1 exactly when the current microword has memRd and memWr both set.
- R9: When ldEn is high at a rising edge, ldData is written to store address ldAddr. A fetch of that same address at that same edge returns the previous content. Later fetches return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ldEn | input | 1 | Control-store write strobe |
| ldAddr | input | 11 | Control-store write address |
| ldData | input | 41 | Microword to write |
| flagN | input | 1 | Negative status flag |
| flagZ | input | 1 | Zero status flag |
| flagV | input | 1 | Overflow status flag |
| flagC | input | 1 | Carry status flag |
| ir | input | 32 | Instruction word being interpreted |
| csAddr | output | 11 | Address of the microword in execution |
| aSel | output | 6 | A-bus register select |
| aFromIr | output | 1 | Take the A select from the instruction |
| bSel | output | 6 | B-bus register select |
| bFromIr | output | 1 | Take the B select from the instruction |
| cSel | output | 6 | Destination register select |
| cFromIr | output | 1 | Take the destination from the instruction |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| aluOp | output | 4 | ALU function code |
| condCode | output | 3 | Sequencing condition of the current word |
| jumpAddr | output | 11 | Jump target of the current word |
| rdWrErr | output | 1 | Current word requests both read and write |

## Verification
The next-address choice uses the flags and ir as they stand during the cycle the microword is in the register. The result shows on csAddr and on every field output one rising edge later. The bench drives inputs on the falling edge. It computes the next address and the fetched word at that point and compares them at the following falling edge, so each expectation is checked exactly one edge after the stimulus it depends on. rdWrErr depends only on the word in the register, so it is checked on the same falling edge as that word. A store write and a fetch of the same address at the same edge are modelled with the fetch reading first.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int ADDR_W = 11;
  localparam int WORD_W = 41;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int REG_W  = 6;
  localparam int ALU_W  = 4;
  localparam int COND_W = 3;
  localparam int IR_W   = 32;

  typedef enum logic [COND_W-1:0] {
    CondNext     = 3'd0,
    CondNeg      = 3'd1,
    CondZero     = 3'd2,
    CondOvf      = 3'd3,
    CondCarry    = 3'd4,
    CondIrBit13  = 3'd5,
    CondAlways   = 3'd6,
    CondDispatch = 3'd7
  } cond_e;

  // first member sits at the most significant end
  typedef struct packed {
    logic [REG_W-1:0]  aSel;
    logic              aFromIr;
    logic [REG_W-1:0]  bSel;
    logic              bFromIr;
    logic [REG_W-1:0]  cSel;
    logic              cFromIr;
    logic              memRd;
    logic              memWr;
    logic [ALU_W-1:0]  aluOp;
    cond_e             cond;
    logic [ADDR_W-1:0] jumpAddr;
  } mword_t;

  typedef enum logic [1:0] {
    SrcInc      = 2'd0,
    SrcJump     = 2'd1,
    SrcDispatch = 2'd2
  } nextSrc_e;

  // strobes from the sequencing control to the store datapath
  typedef struct packed {
    nextSrc_e          src;
    logic [ADDR_W-1:0] nextAddr;
  } seqCtrl_t;

endpackage

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  mword_t            mir,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic              flagN,
  input  logic              flagZ,
  input  logic              flagV,
  input  logic              flagC,
  input  logic [IR_W-1:0]   ir,
  output seqCtrl_t          ctrl
);

  localparam int OPLO_W = 6;
  localparam int PAD_W  = ADDR_W - 1 - 2 - OPLO_W;

  logic              condHit;
  logic [ADDR_W-1:0] incAddr;
  logic [ADDR_W-1:0] dispAddr;

  // wraps naturally at the top of the store
  assign incAddr = curAddr + ADDR_W'(1);

  generate
    if (PAD_W >= 1) begin : g_pad
      assign dispAddr = {1'b1, ir[31:30], ir[24:19], {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign dispAddr = ADDR_W'({1'b1, ir[31:30], ir[24:19]});
    end
  endgenerate

  always_comb begin
    unique case (mir.cond)
      CondNeg:     condHit = flagN;
      CondZero:    condHit = flagZ;
      CondOvf:     condHit = flagV;
      CondCarry:   condHit = flagC;
      CondIrBit13: condHit = ir[13];
      CondAlways:  condHit = 1'b1;
      default:     condHit = 1'b0;
    endcase
  end

  always_comb begin
    if (mir.cond == CondDispatch) begin
      ctrl.src      = SrcDispatch;
      ctrl.nextAddr = dispAddr;
    end else if (condHit) begin
      ctrl.src      = SrcJump;
      ctrl.nextAddr = mir.jumpAddr;
    end else begin
      ctrl.src      = SrcInc;
      ctrl.nextAddr = incAddr;
    end
  end

endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [WORD_W-1:0] ldData,
  input  seqCtrl_t          ctrl,
  output mword_t            mir,
  output logic [ADDR_W-1:0] curAddr
);

  logic [WORD_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] fetchAddr;

  assign fetchAddr = rst ? '0 : ctrl.nextAddr;

  always_ff @(posedge clk) begin
    if (ldEn) store[ldAddr] <= ldData;
  end

  // the address tag travels with the word it fetched
  always_ff @(posedge clk) begin
    mir     <= mword_t'(store[fetchAddr]);
    curAddr <= fetchAddr;
  end

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ldEn,
  input  logic [10:0] ldAddr,
  input  logic [40:0] ldData,
  input  logic        flagN,
  input  logic        flagZ,
  input  logic        flagV,
  input  logic        flagC,
  input  logic [31:0] ir,
  output logic [10:0] csAddr,
  output logic [5:0]  aSel,
  output logic        aFromIr,
  output logic [5:0]  bSel,
  output logic        bFromIr,
  output logic [5:0]  cSel,
  output logic        cFromIr,
  output logic        memRd,
  output logic        memWr,
  output logic [3:0]  aluOp,
  output logic [2:0]  condCode,
  output logic [10:0] jumpAddr,
  output logic        rdWrErr
);

  mword_t            mir;
  logic [ADDR_W-1:0] curAddr;
  seqCtrl_t          ctrl;

  useq_store i_store (
    .clk     (clk),
    .rst     (rst),
    .ldEn    (ldEn),
    .ldAddr  (ldAddr),
    .ldData  (ldData),
    .ctrl    (ctrl),
    .mir     (mir),
    .curAddr (curAddr)
  );

  useq_next i_next (
    .mir     (mir),
    .curAddr (curAddr),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagV   (flagV),
    .flagC   (flagC),
    .ir      (ir),
    .ctrl    (ctrl)
  );

  assign csAddr   = curAddr;
  assign aSel     = mir.aSel;
  assign aFromIr  = mir.aFromIr;
  assign bSel     = mir.bSel;
  assign bFromIr  = mir.bFromIr;
  assign cSel     = mir.cSel;
  assign cFromIr  = mir.cFromIr;
  assign memRd    = mir.memRd;
  assign memWr    = mir.memWr;
  assign aluOp    = mir.aluOp;
  assign condCode = mir.cond;
  assign jumpAddr = mir.jumpAddr;
  assign rdWrErr  = mir.memRd & mir.memWr;

endmodule

// File: rtl/useq_chk.sv
module useq_chk (
  input logic        clk,
  input logic        rst,
  input logic [10:0] csAddr,
  input logic [2:0]  condCode,
  input logic [10:0] jumpAddr,
  input logic [31:0] ir,
  input logic        flagZ
);

  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (rst)
    condCode == 3'd0 |=> csAddr == 11'($past(csAddr) + 11'd1)); // R3

  AST_ZERO_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (condCode == 3'd2 && flagZ) |=> csAddr == $past(jumpAddr)); // R4

  AST_ALWAYS_JUMP: assert property (@(posedge clk) disable iff (rst)
    condCode == 3'd6 |=> csAddr == $past(jumpAddr)); // R5

  AST_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    condCode == 3'd7 |=> csAddr == {1'b1, $past(ir[31:30]), $past(ir[24:19]), 2'b00}); // R6

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (condCode == 3'd0 && csAddr == 11'd2047) |=> csAddr == 11'd0); // R7

endmodule

bind useq_top useq_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .csAddr   (csAddr),
  .condCode (condCode),
  .jumpAddr (jumpAddr),
  .ir       (ir),
  .flagZ    (flagZ)
);

// File: tb/test_useq_top.sv
`timescale 1ns/1ps
module test_useq_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ldEn = 1'b0;
  logic [10:0] ldAddr = '0;
  logic [40:0] ldData = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagV = 1'b0, flagC = 1'b0;
  logic [31:0] ir = '0;
  logic [10:0] csAddr, jumpAddr;
  logic [5:0]  aSel, bSel, cSel;
  logic        aFromIr, bFromIr, cFromIr, memRd, memWr, rdWrErr;
  logic [3:0]  aluOp;
  logic [2:0]  condCode;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  logic [40:0] mm [2048];
  logic [10:0] mAddr;
  logic [40:0] mWord;
  string       addrTag;

  always #4 clk = ~clk;

  useq_top i_useq_top (
    .clk(clk), .rst(rst), .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC), .ir(ir),
    .csAddr(csAddr), .aSel(aSel), .aFromIr(aFromIr), .bSel(bSel),
    .bFromIr(bFromIr), .cSel(cSel), .cFromIr(cFromIr), .memRd(memRd),
    .memWr(memWr), .aluOp(aluOp), .condCode(condCode), .jumpAddr(jumpAddr),
    .rdWrErr(rdWrErr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [40:0] mkWord();
    logic [40:0] w;
    w = {$urandom, $urandom};
    if (w[19] && w[18] && ($urandom % 8 != 0)) w[18] = 1'b0;
    return w;
  endfunction

  task automatic compareAll(input string aTag);
    check(aTag, 64'(csAddr), 64'(mAddr));
    // R1 field slices (R9: content of the fetched word)
    check("R1", 64'({aSel, aFromIr, bSel, bFromIr, cSel, cFromIr, memRd,
                     memWr, aluOp, condCode, jumpAddr}), 64'(mWord));
    check("R1", 64'(aluOp), 64'(mWord[17:14]));
    check("R8", 64'(rdWrErr), 64'(mWord[19] & mWord[18]));
  endtask

  // one cycle: check at falling edge, drive, predict, advance
  task automatic step(input bit allowLoad);
    logic [10:0] nxt;
    logic        hit;
    logic [2:0]  cnd;
    compareAll(addrTag);
    flagN = $urandom; flagZ = $urandom; flagV = $urandom; flagC = $urandom;
    ir    = $urandom;
    ldEn  = allowLoad && ($urandom % 16 == 0);
    ldAddr = $urandom;
    ldData = mkWord();
    cnd = mWord[13:11];
    case (cnd)
      3'd1: hit = flagN;
      3'd2: hit = flagZ;
      3'd3: hit = flagV;
      3'd4: hit = flagC;
      3'd5: hit = ir[13];
      3'd6: hit = 1'b1;
      default: hit = 1'b0;
    endcase
    if (cnd == 3'd7) begin
      nxt = {1'b1, ir[31:30], ir[24:19], 2'b00};
      addrTag = "R6";
    end else if (hit) begin
      nxt = mWord[10:0];
      addrTag = (cnd == 3'd6) ? "R5" : "R4";
    end else begin
      nxt = mAddr + 11'd1;
      addrTag = (mAddr == 11'd2047) ? "R7" : ((cnd == 3'd0) ? "R3" : "R4");
    end
    @(posedge clk);
    mAddr = nxt;
    mWord = mm[nxt];
    if (ldEn) mm[ldAddr] = ldData;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mm[i] = mkWord();
    // 0: jump to 2047 on ir[13]; 2047: plain increment (wrap)
    mm[0]    = {mm[0][40:14], 3'd5, 11'd2047};
    mm[2047] = {mm[2047][40:14], 3'd0, mm[2047][10:0]};
    mm[1]    = {mm[1][40:14], 3'd7, 11'd0};
    @(negedge clk);
    for (int i = 0; i < 2048; i++) begin
      ldEn = 1'b1; ldAddr = 11'(i); ldData = mm[i];
      @(negedge clk);
    end
    ldEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mAddr = '0;
    mWord = mm[0];
    compareAll("R2");
    rst = 1'b0;
    addrTag = "R2";
    // first execution after reset is word 0
    for (int i = 0; i < 200; i++) step(1'b0);
    for (int i = 0; i < 4000; i++) step(1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule